// File: doc/BRIEF.md
# Hold-mode entry and wake-up controller

This block decides when a small core may stop its oscillator and when it may run again. Software writes a 4-bit command. Bit 0 asks for hold. Bit 3 picks the release policy, level or edge. Bits 2:1 pick how long the warm-up lasts once the oscillator restarts. While the block holds, it turns the oscillator off, keeps the timing divider cleared to zero and stalls the core. When the release condition is met, it turns the oscillator back on at once. It then times the warm-up on the divider and lets the core resume.

The controller has three states:

- `ST_RUN`: normal execution.
- `ST_HOLD`: oscillator off, divider cleared, core stalled.
- `ST_WARM`: oscillator on, core stalled while the divider counts.

It has five transitions:

- RUN→HOLD: an accepted hold command.
- RUN→WARM: a level-release request made while the pin is already high, which is refused.
- HOLD→WARM: the release condition.
- WARM→RUN: the warm-up terminal count, which also clears the divider.
- Any state→RUN: reset.

The pin is synchronised through two flops for the refusal decision and for the status bit. In hold, the release is evaluated combinationally from the raw pin, so the oscillator enable can rise before any clock edge.

In the model, `clk` stays available during hold so that the edge-release arming flag can observe the pin. The core's own clock is gated by `osc_en`.

Top module: `hold_ctrl`

## Requirements
- R1: After reset, or whenever the core is not stalled, `osc_en` is 1 and `core_stall` is 0. The divider counts up from 0 while running.
- R2: A command write whose bit 0 is 0 has no effect: the core stays unstalled and the oscillator stays on.
- R3: A command write with bit 0 = 1 in RUN stalls the core from the next cycle. Hold is actually entered in every case except the refusal of R5. While in hold, `osc_en` is 0 and `tg_count` reads 0 until release.
- R4: In level mode (bit 3 = 1), a high `hold_pin` during hold raises `osc_en` in the same cycle, without waiting for a clock edge.
- R5: In level mode, if the synchronised pin is already high when the command is accepted, hold is refused. The oscillator never stops and the warm-up starts on the write edge.
- R6: In edge mode (bit 3 = 0), hold is entered even when the pin is high. Release happens only when the pin goes high after having been low while in hold.
- R7: The warm-up stalls the core with the oscillator on for 2^SHORT_LOG2 cycles for code 01, 2^MID_LOG2 cycles for codes 10 and 11, and 2^LONG_LOG2 cycles for code 00. The code is taken from bits 2:1 of the command.
- R8: In the first cycle after the stall ends, `tg_count` is 0. It increments by one per cycle after that.
- R9: Driving `rst_n` low during hold immediately restores the RUN outputs (`osc_en` = 1, `core_stall` = 0).
- R10: `status_hold_n` is the inverse of `hold_pin`, delayed by two clock edges.
- R11: Command writes are ignored while the core is stalled. A hold request written during warm-up neither lengthens it nor re-enters hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Basic clock of the controller |
| rst_n | input | 1 | Asynchronous active-low reset; also ends hold |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 4 | Command: [3] level/edge, [2:1] warm-up code, [0] enter hold |
| hold_pin | input | 1 | External hold request / wake pin |
| osc_en | output | 1 | Oscillator enable |
| div_clr | output | 1 | Clear pulse for the timing divider |
| core_stall | output | 1 | Holds the core off while in hold or warm-up |
| status_hold_n | output | 1 | Synchronised, inverted pin level |
| tg_count | output | DIV_W | Timing divider value |

## Verification
Timing after a command written on edge k:

- The stall is visible after edge k.
- In a refused level request, that first sample already belongs to the warm-up.
- Release raises `osc_en` combinationally, and the bench samples it 1 ns after changing the pin.
- The warm-up then covers exactly 2^N negedge samples with stall and oscillator both high.
- `tg_count` reads 0 on the first unstalled sample and 1 on the next.

The status bit is due two rising edges after a pin change. Every check is taken at the falling edge, with inputs driven just after that sample.

// File: rtl/hold_pkg.sv
package hold_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_WARM = 2'd2
    } hold_state_e;

    typedef enum logic [1:0] {
        WU_LONG  = 2'b00,
        WU_SHORT = 2'b01,
        WU_MID   = 2'b10,
        WU_MID2  = 2'b11
    } warm_code_e;

    typedef struct packed {
        logic       level_mode;
        warm_code_e warm_code;
        logic       enter;
    } hold_cmd_t;

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hold_divider.sv
module hold_divider #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  count <= '0;
        else if (clr) count <= '0;
        else if (en)  count <= count + 1'b1;
    end
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
    import hold_pkg::*;
#(
    parameter int DIV_W      = 18,
    parameter int SHORT_LOG2 = 12,
    parameter int MID_LOG2   = 14,
    parameter int LONG_LOG2  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [3:0]       cmd_data,
    input  logic             pin_raw,
    input  logic             pin_sync,
    input  logic [DIV_W-1:0] div_count,
    output logic             osc_en,
    output logic             div_clr,
    output logic             core_stall
);
    localparam logic [DIV_W-1:0] MASK_SHORT = DIV_W'((64'd1 << SHORT_LOG2) - 64'd1);
    localparam logic [DIV_W-1:0] MASK_MID   = DIV_W'((64'd1 << MID_LOG2) - 64'd1);
    localparam logic [DIV_W-1:0] MASK_LONG  = DIV_W'((64'd1 << LONG_LOG2) - 64'd1);

    hold_state_e state_q, state_d;
    logic        level_q;
    warm_code_e  code_q;
    logic        low_seen_q;

    hold_cmd_t   cmd;
    logic        accept, refuse, release_now, warm_done;
    logic [DIV_W-1:0] warm_mask;

    assign cmd         = hold_cmd_t'(cmd_data);
    assign accept      = (state_q == ST_RUN) && cmd_we && cmd.enter;
    assign refuse      = accept && cmd.level_mode && pin_sync;
    assign release_now = level_q ? pin_raw : (low_seen_q && pin_raw);

    always_comb begin
        unique case (code_q)
            WU_SHORT: warm_mask = MASK_SHORT;
            WU_LONG:  warm_mask = MASK_LONG;
            default:  warm_mask = MASK_MID;
        endcase
    end

    assign warm_done = (state_q == ST_WARM) && ((div_count & warm_mask) == warm_mask);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (accept)      state_d = refuse ? ST_WARM : ST_HOLD;
            ST_HOLD: if (release_now) state_d = ST_WARM;
            ST_WARM: if (warm_done)   state_d = ST_RUN;
            default:                  state_d = ST_RUN;
        endcase
    end

    // state register and captured command fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_RUN;
            level_q    <= 1'b0;
            code_q     <= WU_MID;
            low_seen_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                level_q    <= cmd.level_mode;
                code_q     <= cmd.warm_code;
                low_seen_q <= !pin_sync;
            end else if (state_q == ST_HOLD) begin
                low_seen_q <= low_seen_q || !pin_raw;
            end
        end
    end

    // outputs per state
    always_comb begin
        osc_en     = 1'b1;
        div_clr    = 1'b0;
        core_stall = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                div_clr = accept;
            end
            ST_HOLD: begin
                osc_en     = release_now;
                div_clr    = 1'b1;
                core_stall = 1'b1;
            end
            ST_WARM: begin
                div_clr    = warm_done;
                core_stall = 1'b1;
            end
            default: begin
                div_clr = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl #(
    parameter int DIV_W      = 18,
    parameter int SHORT_LOG2 = 12,
    parameter int MID_LOG2   = 14,
    parameter int LONG_LOG2  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [3:0]       cmd_data,
    input  logic             hold_pin,
    output logic             osc_en,
    output logic             div_clr,
    output logic             core_stall,
    output logic             status_hold_n,
    output logic [DIV_W-1:0] tg_count
);
    logic pin_sync;

    hold_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (hold_pin),
        .q     (pin_sync)
    );

    hold_divider #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .en    (osc_en),
        .count (tg_count)
    );

    hold_fsm #(
        .DIV_W      (DIV_W),
        .SHORT_LOG2 (SHORT_LOG2),
        .MID_LOG2   (MID_LOG2),
        .LONG_LOG2  (LONG_LOG2)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (cmd_we),
        .cmd_data   (cmd_data),
        .pin_raw    (hold_pin),
        .pin_sync   (pin_sync),
        .div_count  (tg_count),
        .osc_en     (osc_en),
        .div_clr    (div_clr),
        .core_stall (core_stall)
    );

    assign status_hold_n = !pin_sync;
endmodule

// File: rtl/hold_ctrl_chk.sv
module hold_ctrl_chk #(
    parameter int DIV_W     = 18,
    parameter int LONG_LOG2 = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic [3:0]       cmd_data,
    input logic             osc_en,
    input logic             core_stall,
    input logic [DIV_W-1:0] tg_count
);
    localparam int CW = LONG_LOG2 + 2;
    logic [CW-1:0] warm_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    warm_cnt <= '0;
        else if (core_stall && osc_en) warm_cnt <= warm_cnt + 1'b1;
        else                           warm_cnt <= '0;
    end

    p_run_osc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !core_stall |-> osc_en);

    p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_stall && cmd_we && !cmd_data[0]) |=> !core_stall);

    p_hold_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_stall && cmd_we && cmd_data[0]) |=> core_stall);

    p_hold_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (tg_count == '0));

    p_warm_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        warm_cnt <= CW'((64'd1 << LONG_LOG2) + 64'd1));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_stall) |-> (tg_count == '0));
endmodule

bind hold_ctrl hold_ctrl_chk #(
    .DIV_W     (DIV_W),
    .LONG_LOG2 (LONG_LOG2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_data   (cmd_data),
    .osc_en     (osc_en),
    .core_stall (core_stall),
    .tg_count   (tg_count)
);

// File: tb/hold_ctrl_tb.sv
module hold_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 8;
    localparam int SHORT_LOG2 = 3;
    localparam int MID_LOG2 = 4;
    localparam int LONG_LOG2 = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_we = 1'b0;
    logic [3:0] cmd_data = 4'd0;
    logic hold_pin = 1'b0;
    logic osc_en, div_clr, core_stall, status_hold_n;
    logic [DIV_W-1:0] tg_count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    hold_ctrl #(
        .DIV_W(DIV_W), .SHORT_LOG2(SHORT_LOG2),
        .MID_LOG2(MID_LOG2), .LONG_LOG2(LONG_LOG2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .hold_pin(hold_pin), .osc_en(osc_en), .div_clr(div_clr),
        .core_stall(core_stall), .status_hold_n(status_hold_n),
        .tg_count(tg_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset();
        cmd_we = 1'b0;
        rst_n = 1'b0;
        repeat (2) cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    function automatic int warm_len(input logic [1:0] code);
        if (code == 2'b00) return 1 << LONG_LOG2;
        if (code == 2'b01) return 1 << SHORT_LOG2;
        return 1 << MID_LOG2;
    endfunction

    // counts stalled samples starting with the current one, then checks restart
    task automatic measure_warm(input int exp_len, input string req);
        int n = 0;
        while (core_stall && n < 200) begin
            if (!osc_en) check(1'b0, "R7 osc during warm-up", 0, 1);
            n++;
            cyc();
        end
        check(n == exp_len, req, n, exp_len);
        check(tg_count == 0, "R8 divider zero after warm-up", int'(tg_count), 0);
        cyc();
        check(tg_count == 1, "R8 divider counts after warm-up", int'(tg_count), 1);
        check(osc_en && !core_stall, "R1 running after warm-up", int'(core_stall), 0);
    endtask

    initial begin
        do_reset();

        // sweep: every command code against both pin levels at the write
        for (int code = 0; code < 16; code++) begin
            for (int p = 0; p < 2; p++) begin
                logic [3:0] c;
                c = 4'(code);
                do_reset();
                hold_pin = p[0];
                repeat (3) cyc();
                check(osc_en && !core_stall, "R1 reset state", int'(core_stall), 0);
                cmd_data = c;
                cmd_we = 1'b1;
                cyc();
                cmd_we = 1'b0;
                if (!c[0]) begin
                    check(!core_stall && osc_en, "R2 command without enter ignored", int'(core_stall), 0);
                    cyc();
                    check(!core_stall, "R2 still running", int'(core_stall), 0);
                end else if (c[3] && p == 1) begin
                    check(core_stall && osc_en, "R5 refused hold keeps oscillator", int'(osc_en), 1);
                    measure_warm(warm_len(c[2:1]), "R5 R7 warm-up length after refusal");
                end else begin
                    check(core_stall && !osc_en, "R3 hold entered", int'(osc_en), 0);
                    check(tg_count == 0, "R3 divider cleared in hold", int'(tg_count), 0);
                    if (!c[3] && p == 1) begin
                        repeat (4) cyc();
                        check(!osc_en, "R6 edge hold kept while pin high", int'(osc_en), 0);
                        hold_pin = 1'b0;
                        #1;
                        check(!osc_en, "R6 falling pin does not release", int'(osc_en), 0);
                        repeat (2) cyc();
                        check(!osc_en && core_stall, "R6 still held while low", int'(osc_en), 0);
                    end else begin
                        repeat (3) cyc();
                        check(!osc_en && tg_count == 0, "R3 hold persists", int'(osc_en), 0);
                    end
                    hold_pin = 1'b1;
                    #1;
                    check(osc_en, c[3] ? "R4 level release immediate" : "R6 rising edge release",
                          int'(osc_en), 1);
                    cyc();
                    measure_warm(warm_len(c[2:1]), "R7 warm-up length after release");
                end
            end
        end

        // R9: reset ends hold
        do_reset();
        hold_pin = 1'b0;
        repeat (3) cyc();
        cmd_data = 4'b0101;
        cmd_we = 1'b1;
        cyc();
        cmd_we = 1'b0;
        cyc();
        check(!osc_en && core_stall, "R9 in hold before reset", int'(osc_en), 0);
        rst_n = 1'b0;
        #1;
        check(osc_en && !core_stall, "R9 reset releases hold", int'(core_stall), 0);
        cyc();
        rst_n = 1'b1;
        repeat (3) cyc();
        check(osc_en && !core_stall, "R9 running after reset", int'(core_stall), 0);

        // R10: status bit delay and polarity
        do_reset();
        hold_pin = 1'b0;
        repeat (3) cyc();
        check(status_hold_n == 1'b1, "R10 low pin reads 1", int'(status_hold_n), 1);
        hold_pin = 1'b1;
        cyc();
        check(status_hold_n == 1'b1, "R10 one edge not yet visible", int'(status_hold_n), 1);
        cyc();
        check(status_hold_n == 1'b0, "R10 high pin reads 0", int'(status_hold_n), 0);
        hold_pin = 1'b0;
        repeat (2) cyc();
        check(status_hold_n == 1'b1, "R10 back to 1", int'(status_hold_n), 1);

        // R11: hold command during warm-up ignored
        do_reset();
        hold_pin = 1'b1;
        repeat (3) cyc();
        cmd_data = 4'b1011;
        cmd_we = 1'b1;
        cyc();
        cmd_we = 1'b0;
        begin
            int n = 0;
            while (core_stall && n < 200) begin
                n++;
                cmd_data = 4'b0101;
                cmd_we = (n == 3);
                cyc();
                cmd_we = 1'b0;
                if (!osc_en) check(1'b0, "R11 oscillator stopped in warm-up", 0, 1);
            end
            check(n == (1 << SHORT_LOG2), "R11 warm-up length unchanged", n, 1 << SHORT_LOG2);
        end
        repeat (2) cyc();
        check(!core_stall && osc_en, "R11 no hold after ignored write", int'(core_stall), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule